// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block drives the host side of programmed-I/O cycles on a parallel ATA channel that has a master drive and a slave drive. Software loads a small bank of timing bytes. The bank holds a shared address-setup register plus three timing bytes for each drive: 16-bit read, 16-bit write and 8-bit. Each access is then posed on a request input. The request carries the drive, the direction, the width, the register block (command or control) and the register address. The block runs the access through an address-setup phase, a strobe-active phase and a recovery phase. Each phase length comes from the programmed nibbles, stored as clocks minus one. The block then acknowledges the access.

The block drives the chip selects, the register address, the read and write strobes, the data-bus output enable and the write data. It captures read data from the bus. The drive can stretch the active phase by holding its ready line low. Every access takes a snapshot of its timing values when it is accepted. Software may therefore rewrite the bank at any time without disturbing an access already on the cable.

Top module: `ide_pio_strobe`

## Requirements
- R1: After reset, `busy`, `ack` and `ata_dd_oe` are 0, both strobes are high, `ata_cs_n` is 2'b11, `ata_addr` is 0 and `rdata` is 0.
- R2: Configuration address 0 holds the setup nibbles, with the master in bits 3:0 and the slave in bits 7:4. Address 1+3*d+s holds the timing byte of drive d (0 master, 1 slave) for slot s. Slot 0 is 16-bit read, slot 1 is 16-bit write and slot 2 is 8-bit, either direction. Address 7 is ignored. Each access uses the byte that matches its drive, width and direction.
- R3: In a timing byte, bits 7:4 are the active count and bits 3:0 the recovery count. A field value N yields a phase of N+1 clocks, so each phase lasts 1 to 16 clocks.
- R4: After reset every configuration byte reads as 8'hFF, so an unprogrammed access has 16 setup, 16 active and 16 recovery clocks.
- R5: Each access runs in this order: setup (address and chip select valid, both strobes high), active (one strobe low), recovery (both strobes high). Chip select and address stay valid throughout. `ata_cs_n` is 2'b10 for command-block accesses and 2'b01 for control-block accesses.
- R6: When the active count has expired and `ata_iordy` is low, the active phase continues. It ends at the first clock edge where `ata_iordy` is high. A ready line that is low earlier but high by the time the count expires causes no extension.
- R7: A read captures `ata_dd_in` at the last clock of the active phase into `rdata`. An 8-bit read keeps only bits 7:0, and bits 15:8 of `rdata` are 0.
- R8: On a write, `ata_dd_oe` is high from the first setup clock to the last active clock and low at all other times. While it is high, `ata_dd_out` carries the write data, with bits 15:8 forced to 0 on an 8-bit write. Reads never raise `ata_dd_oe`.
- R9: `busy` is high from the clock after a request is accepted until recovery ends. `ack` is high for exactly one clock, the first clock with `busy` low. A request raised while `busy` is high is not taken.
- R10: A configuration write made during an access does not change that access's phase lengths. It applies from the next access on.
- R11: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte value |
| req | input | 1 | Access request, taken when idle |
| drv_slave | input | 1 | 1 selects the slave drive |
| acc_write | input | 1 | 1 for a write access |
| acc_8bit | input | 1 | 1 for an 8-bit access |
| acc_ctl | input | 1 | 1 for the control register block |
| acc_reg | input | 3 | Register address within the block |
| acc_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |
| rdata | output | 16 | Captured read data |
| ata_cs_n | output | 2 | Chip selects, active low (bit 0 command, bit 1 control) |
| ata_addr | output | 3 | Register address on the cable |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_out | output | 16 | Data driven onto the bus |
| ata_dd_in | input | 16 | Data from the bus |
| ata_iordy | input | 1 | Drive ready, low to stretch the strobe |

## Verification
A corrupted phase counter or a wrong slot choice shows up within the access, as a setup, strobe or recovery length off by a whole number of clocks. The bench measures each length directly at the pins. A timing snapshot that is not held shows as lengths that follow a configuration write made during setup. A read capture taken on the wrong edge returns the bus value from a neighbouring clock. The bench drives a different bus value on every active clock, so that fault appears in `rdata` at `ack`. Enable and strobe overlap faults are caught on the clock they occur, through per-clock pin checks during every access.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;
  localparam int unsigned SLOT_N = 3;
  localparam int unsigned DRV_N  = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_t;

  typedef struct packed {
    logic [NIB_W-1:0] setup;
    logic [NIB_W-1:0] act;
    logic [NIB_W-1:0] rec;
  } tm_t;

  // slot: 0 = 16-bit read, 1 = 16-bit write, 2 = 8-bit
  function automatic logic [1:0] slot_of(input logic wr, input logic w8);
    if (w8) return 2'd2;
    return wr ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] byte_index(input logic drv, input logic [1:0] slot);
    return (drv ? 3'(SLOT_N) : 3'd0) + {1'b0, slot};
  endfunction

  function automatic logic [15:0] bus_word(input logic w8, input logic [15:0] d);
    return w8 ? {8'h00, d[7:0]} : d;
  endfunction
endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
  import ide_pio_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              drv_slave,
  input  logic              acc_write,
  input  logic              acc_8bit,
  output tm_t               tm_o
);
  localparam int unsigned TB_N = DRV_N * SLOT_N;

  logic [BYTE_W-1:0] setup_q;
  logic [BYTE_W-1:0] tbyte_q [TB_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                setup_q <= '1;
    else if (cfg_we && cfg_addr == AW'(0))     setup_q <= cfg_wdata;
  end

  for (genvar i = 0; i < TB_N; i++) begin : g_tb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                tbyte_q[i] <= '1;
      else if (cfg_we && cfg_addr == AW'(i + 1)) tbyte_q[i] <= cfg_wdata;
    end
  end

  logic [2:0]        idx;
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    idx        = byte_index(drv_slave, slot_of(acc_write, acc_8bit));
    sel_byte   = tbyte_q[idx];
    tm_o.setup = drv_slave ? setup_q[BYTE_W-1:NIB_W] : setup_q[NIB_W-1:0];
    tm_o.act   = sel_byte[BYTE_W-1:NIB_W];
    tm_o.rec   = sel_byte[NIB_W-1:0];
  end
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  tm_t    tm_i,
  input  logic   iordy,
  output phase_t ph_o,
  output logic   accept_o,
  output logic   act_done_o,
  output logic   ack_o
);
  phase_t           ph_q;
  logic [NIB_W-1:0] cnt_q;
  tm_t              tm_q;
  logic             ack_q;
  logic             cnt_zero, rec_done;

  assign cnt_zero   = (cnt_q == '0);
  assign accept_o   = (ph_q == PH_IDLE) && req;
  assign act_done_o = (ph_q == PH_ACT) && cnt_zero && iordy;
  assign rec_done   = (ph_q == PH_REC) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tm_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= rec_done;
      unique case (ph_q)
        PH_IDLE: if (accept_o) begin
          ph_q  <= PH_SETUP;
          cnt_q <= tm_i.setup;
          tm_q  <= tm_i;
        end
        PH_SETUP: if (cnt_zero) begin
          ph_q  <= PH_ACT;
          cnt_q <= tm_q.act;
        end else cnt_q <= cnt_q - 1'b1;
        PH_ACT: if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (iordy) begin
            ph_q  <= PH_REC;
            cnt_q <= tm_q.rec;
          end
        PH_REC: if (cnt_zero) ph_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ph_o  = ph_q;
  assign ack_o = ack_q;

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack_q |=> !ack_q);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_q != PH_IDLE) |-> ack_q);
  // R10
  tm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> $stable(tm_q));
  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACT && cnt_zero && !iordy) |=> ph_q == PH_ACT);
endmodule

// File: rtl/ide_pio_dp.sv
module ide_pio_dp
  import ide_pio_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned RA = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        ph_i,
  input  logic          accept_i,
  input  logic          act_done_i,
  input  logic          acc_write,
  input  logic          acc_8bit,
  input  logic          acc_ctl,
  input  logic [RA-1:0] acc_reg,
  input  logic [DW-1:0] acc_wdata,
  input  logic [DW-1:0] dd_in,
  output logic [DW-1:0] rdata,
  output logic [1:0]    cs_n,
  output logic [RA-1:0] addr,
  output logic          rd_n,
  output logic          wr_n,
  output logic          dd_oe,
  output logic [DW-1:0] dd_out
);
  logic          wr_q, w8_q, ctl_q;
  logic [RA-1:0] reg_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          in_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; w8_q <= 1'b0; ctl_q <= 1'b0;
      reg_q <= '0; wd_q <= '0;
    end else if (accept_i) begin
      wr_q  <= acc_write;
      w8_q  <= acc_8bit;
      ctl_q <= acc_ctl;
      reg_q <= acc_reg;
      wd_q  <= bus_word(acc_8bit, acc_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_q <= '0;
    else if (act_done_i && !wr_q) rd_q <= bus_word(w8_q, dd_in);
  end

  assign in_acc = (ph_i != PH_IDLE);
  assign rdata  = rd_q;
  assign cs_n   = !in_acc ? 2'b11 : (ctl_q ? 2'b01 : 2'b10);
  assign addr   = in_acc ? reg_q : '0;
  assign rd_n   = !((ph_i == PH_ACT) && !wr_q);
  assign wr_n   = !((ph_i == PH_ACT) && wr_q);
  assign dd_oe  = wr_q && (ph_i == PH_SETUP || ph_i == PH_ACT);
  assign dd_out = dd_oe ? wd_q : '0;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R8
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n) dd_oe |-> rd_n);
  // R5
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $countones(cs_n) == 1);
endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe
  import ide_pio_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned RA = 3,
  parameter int unsigned CA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA-1:0]     cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              req,
  input  logic              drv_slave,
  input  logic              acc_write,
  input  logic              acc_8bit,
  input  logic              acc_ctl,
  input  logic [RA-1:0]     acc_reg,
  input  logic [DW-1:0]     acc_wdata,
  output logic              ack,
  output logic              busy,
  output logic [DW-1:0]     rdata,
  output logic [1:0]        ata_cs_n,
  output logic [RA-1:0]     ata_addr,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic              ata_dd_oe,
  output logic [DW-1:0]     ata_dd_out,
  input  logic [DW-1:0]     ata_dd_in,
  input  logic              ata_iordy
);
  tm_t    tm_sel;
  phase_t ph;
  logic   accept, act_done;

  ide_pio_regs #(.AW(CA)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .drv_slave(drv_slave), .acc_write(acc_write),
    .acc_8bit(acc_8bit), .tm_o(tm_sel));

  ide_pio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .tm_i(tm_sel), .iordy(ata_iordy),
    .ph_o(ph), .accept_o(accept), .act_done_o(act_done), .ack_o(ack));

  ide_pio_dp #(.DW(DW), .RA(RA)) u_dp (
    .clk(clk), .rst_n(rst_n), .ph_i(ph), .accept_i(accept), .act_done_i(act_done),
    .acc_write(acc_write), .acc_8bit(acc_8bit), .acc_ctl(acc_ctl),
    .acc_reg(acc_reg), .acc_wdata(acc_wdata), .dd_in(ata_dd_in), .rdata(rdata),
    .cs_n(ata_cs_n), .addr(ata_addr), .rd_n(ata_rd_n), .wr_n(ata_wr_n),
    .dd_oe(ata_dd_oe), .dd_out(ata_dd_out));

  assign busy = (ph != PH_IDLE);
endmodule

// File: tb/ide_pio_strobe_test.sv
module ide_pio_strobe_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic req = 0, drv_slave = 0, acc_write = 0, acc_8bit = 0, acc_ctl = 0;
  logic [2:0] acc_reg = 0; logic [15:0] acc_wdata = 0;
  logic ack, busy; logic [15:0] rdata;
  logic [1:0] ata_cs_n; logic [2:0] ata_addr;
  logic ata_rd_n, ata_wr_n, ata_dd_oe; logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = 0; logic ata_iordy = 1;

  int checks = 0, errors = 0;
  logic [7:0] mreg [0:6];

  always #2 clk = ~clk;

  ide_pio_strobe uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int slot_idx(input bit sl, input bit wr, input bit w8);
    return 1 + (sl ? 3 : 0) + (w8 ? 2 : (wr ? 1 : 0));
  endfunction

  function automatic int setup_len(input bit sl);
    return (sl ? int'(mreg[0][7:4]) : int'(mreg[0][3:0])) + 1;
  endfunction

  task automatic cfg_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 7) mreg[a] = d;
  endtask

  task automatic do_acc(input bit sl, input bit wr, input bit w8, input bit ctl,
                        input logic [2:0] ra, input logic [15:0] wd, input int k,
                        input bit midw, input bit rereq);
    int es, ea, er, s, a, r, guard, mid_idx;
    logic [7:0] b, mid_val;
    logic [15:0] last_in, exp_out, old_rd;
    bit bad_cs, bad_oe, bad_dir, bad_out, done, bad_flow;
    b = mreg[slot_idx(sl, wr, w8)];
    es = setup_len(sl); ea = int'(b[7:4]) + 1; er = int'(b[3:0]) + 1;
    if (k > ea) ea = k;
    exp_out = w8 ? {8'h00, wd[7:0]} : wd;
    old_rd = rdata;
    s = 0; a = 0; r = 0; guard = 0; done = 0; last_in = 0;
    bad_cs = 0; bad_oe = 0; bad_dir = 0; bad_out = 0; bad_flow = 0;
    mid_idx = slot_idx(sl, wr, w8); mid_val = 8'($urandom);
    @(negedge clk);
    ata_iordy = (k == 0);
    req = 1; drv_slave = sl; acc_write = wr; acc_8bit = w8; acc_ctl = ctl;
    acc_reg = ra; acc_wdata = wd;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
      cfg_we = 0;
      req = 0;
      acc_wdata = 16'($urandom); drv_slave = ~sl; acc_write = ~wr;
      if (ack) done = 1;
      else if (!busy) bad_flow = 1;
      else begin
        if (ata_cs_n != (ctl ? 2'b01 : 2'b10) || ata_addr != ra) bad_cs = 1;
        if (!ata_rd_n || !ata_wr_n) begin
          a++;
          if (ata_rd_n == ata_wr_n || ata_wr_n == wr) bad_dir = 1;
          if (ata_dd_oe != wr) bad_oe = 1;
          if (wr && ata_dd_out != exp_out) bad_out = 1;
          if (a == k) ata_iordy = 1;
          ata_dd_in = 16'($urandom);
          last_in = ata_dd_in;
          if (r != 0) bad_flow = 1;
        end else if (a == 0) begin
          s++;
          if (ata_dd_oe != wr) bad_oe = 1;
          if (wr && ata_dd_out != exp_out) bad_out = 1;
          if (midw && s == 1) begin
            cfg_we = 1; cfg_addr = 3'(mid_idx); cfg_wdata = mid_val;
          end
        end else begin
          r++;
          if (ata_dd_oe) bad_oe = 1;
          req = rereq;
        end
      end
    end
    req = 0;
    if (midw) mreg[mid_idx] = mid_val;
    ata_iordy = 1;
    chk(s == es, "R3 setup length", s, es);
    chk(a == ea, (k > 0) ? "R6 active length with ready wait" : "R3 active length", a, ea);
    chk(r == er, "R3 recovery length", r, er);
    chk(!bad_cs, "R5 chip select/address", ata_cs_n, ctl ? 1 : 2);
    chk(!bad_dir && !bad_flow && done, "R5 phase order/strobe", bad_dir, 0);
    chk(!bad_oe && !bad_out, "R8 output enable/write data", ata_dd_out, exp_out);
    if (!wr) chk(rdata == (w8 ? {8'h00, last_in[7:0]} : last_in), "R7 read capture",
                 rdata, w8 ? {8'h00, last_in[7:0]} : last_in);
    else chk(rdata == old_rd, "R7 write keeps rdata", rdata, old_rd);
    if (rereq) begin
      @(negedge clk);
      chk(!busy && !ack, "R9 request during busy not taken", busy, 0);
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 7; i++) mreg[i] = 8'hFF;
    #1;
    chk(!busy && !ack && ata_rd_n && ata_wr_n && !ata_dd_oe && ata_cs_n == 2'b11
        && ata_addr == 0 && rdata == 0, "R1 reset state", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n, "R1 idle after reset", ata_cs_n, 3);
    // R4 unprogrammed slowest timing
    do_acc(0, 0, 0, 0, 3'd7, 16'h0, 0, 0, 0);
    do_acc(1, 1, 0, 1, 3'd6, 16'hBEEF, 0, 0, 0);
    // R2 distinct values per slot
    cfg_write(0, 8'h52);
    cfg_write(1, 8'h31); cfg_write(2, 8'h14); cfg_write(3, 8'h60);
    cfg_write(4, 8'h23); cfg_write(5, 8'h05); cfg_write(6, 8'h42);
    cfg_write(7, 8'h00);
    for (int i = 0; i < 8; i++) do_acc(i[2], i[1], i[0], 0, 3'(i), 16'h1357 + 16'(i), 0, 0, 0);
    // R3 extremes
    cfg_write(0, 8'hF0); cfg_write(1, 8'h00); cfg_write(4, 8'hFF);
    do_acc(0, 0, 0, 0, 3'd1, 16'h0, 0, 0, 0);
    do_acc(1, 0, 0, 1, 3'd2, 16'h0, 0, 0, 0);
    // R6 ready waits
    cfg_write(1, 8'h12);
    do_acc(0, 0, 0, 0, 3'd0, 16'h0, 6, 0, 0);
    cfg_write(2, 8'h72);
    do_acc(0, 1, 0, 0, 3'd0, 16'hA5A5, 3, 0, 0);
    // R7 R8 8-bit paths
    cfg_write(3, 8'h21);
    do_acc(0, 1, 1, 0, 3'd3, 16'hCAFE, 0, 0, 0);
    do_acc(0, 0, 1, 1, 3'd4, 16'h0, 0, 0, 0);
    // R10 mid-access writes, R9 re-request
    cfg_write(0, 8'h33);
    do_acc(0, 0, 0, 0, 3'd5, 16'h0, 0, 1, 0);
    do_acc(0, 0, 0, 0, 3'd5, 16'h0, 0, 0, 0);
    do_acc(1, 1, 0, 0, 3'd6, 16'h7777, 0, 1, 1);
    do_acc(1, 1, 0, 0, 3'd6, 16'h8888, 0, 0, 0);
    // random mix
    for (int n = 0; n < 80; n++) begin
      int roll;
      roll = int'($urandom % 4);
      if (roll == 0) cfg_write(int'($urandom % 8), 8'($urandom));
      do_acc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
             16'($urandom), (($urandom % 4) == 0) ? int'($urandom % 20) : 0,
             (($urandom % 6) == 0), (($urandom % 5) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule